// File: doc/BRIEF.md
# Banked Register File Address Unit

This block is the data-memory access path of a small 8-bit controller whose register file is split into two banks of 128 locations. An instruction names a location with a 7-bit offset; a separate bank bit picks which half of the 256-entry space the offset lands in. Offset zero has no storage of its own. An access there is redirected through an 8-bit pointer register, which can reach any of the 256 locations.

The block holds the general-purpose RAM and the pointer register. Four offsets are special in both banks. The pointer sits at offset 0x04. Three control registers are held outside the block: the low program-counter byte at 0x02, the status byte at 0x03 and the upper-address latch at 0x0A. These special offsets resolve to one shared location whichever bank is selected. The external registers are reached through a one-hot select output, a write strobe and a read-data input. Reads are combinational. Writes take effect on the rising clock edge.

Top module: `bank_addr_unit`

## Requirements
- R1: A direct access (offset not zero) targets physical address {bank_sel, file_addr}. Each ordinary RAM offset holds separate storage in bank 0 and bank 1.
- R2: The pointer register is reached at offset 0x04 in either bank, and it is one register for both banks. After reset it holds 0x00.
- R3: An access at offset 0x00 uses the pointer value as the full 8-bit physical address, for both reads and writes.
- R4: When an access at offset 0x00 finds that the pointer's low 7 bits are zero (address 0x00 or 0x80), the read returns 0x00 and a write changes nothing.
- R5: A resolved offset of 0x02 sets ext_sel bit 0, 0x03 sets bit 1 and 0x0A sets bit 2, in either bank. While one is selected, rd_data equals ext_rd_data and ext_we follows wr_en.
- R6: Storage changes only on a rising clock edge with wr_en high. With wr_en low, no stored value changes. rd_data reflects the current address and storage without a clock.
- R7: An indirect write whose pointer addresses offset 0x04 (0x04 or 0x84) loads the pointer itself.
- R8: ext_sel is all zero and ext_we is low whenever the resolved target is RAM, the pointer or the null location.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of the pointer register |
| file_addr | input | 7 | Offset field from the instruction |
| bank_sel | input | 1 | Bank bit, eighth address bit for direct access |
| wr_en | input | 1 | Write enable for the current access |
| wr_data | input | 8 | Data to write |
| rd_data | output | 8 | Data read from the resolved location |
| ext_sel | output | 3 | One-hot select of the external control registers |
| ext_we | output | 1 | Write strobe for the selected external register |
| ext_rd_data | input | 8 | Read data returned by the selected external register |

## Verification
The assertions assume that file_addr, bank_sel, wr_en and wr_data are stable around each rising edge. They also assume that the pointer value seen by an indirect access is the one committed on the previous edge. The bench meets both conditions by driving every input at the falling edge and holding it for a full cycle. The RAM has no reset, so the bench's reference model only compares RAM locations it has already written. Random offsets, banks and write enables are mixed with a full sweep of the pointer across all 256 addresses. This covers the null and self-pointing cases without needing special stimulus.

// File: rtl/bank_addr_unit.sv
module bank_addr_unit #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-2:0] file_addr,
  input  logic          bank_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic [2:0]    ext_sel,
  output logic          ext_we,
  input  logic [DW-1:0] ext_rd_data
);
  localparam int OW    = DW - 1;
  localparam int DEPTH = 1 << DW;
  localparam logic [OW-1:0] OFS_NULL = OW'(0);
  localparam logic [OW-1:0] OFS_PCL  = OW'(2);
  localparam logic [OW-1:0] OFS_STAT = OW'(3);
  localparam logic [OW-1:0] OFS_PTR  = OW'(4);
  localparam logic [OW-1:0] OFS_PCH  = OW'(10);

  logic [DW-1:0] ram [DEPTH];
  logic [DW-1:0] ptr_q;

  logic          indirect;
  logic [DW-1:0] eff;
  logic [OW-1:0] ofs;
  logic          hit_null, hit_ptr, hit_ram;

  assign indirect = (file_addr == OFS_NULL);
  assign eff      = indirect ? ptr_q : {bank_sel, file_addr};
  assign ofs      = eff[OW-1:0];

  assign hit_null = (ofs == OFS_NULL);
  assign hit_ptr  = (ofs == OFS_PTR);
  assign ext_sel  = {ofs == OFS_PCH, ofs == OFS_STAT, ofs == OFS_PCL};
  assign hit_ram  = !(hit_null || hit_ptr || (|ext_sel));
  assign ext_we   = wr_en && (|ext_sel);

  always_comb begin
    if (hit_null)      rd_data = '0;
    else if (hit_ptr)  rd_data = ptr_q;
    else if (|ext_sel) rd_data = ext_rd_data;
    else               rd_data = ram[eff];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ptr_q <= '0;
    else if (wr_en && hit_ptr) ptr_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (wr_en && hit_ram) ram[eff] <= wr_data;
  end
endmodule

// File: rtl/bank_addr_unit_chk.sv
module bank_addr_unit_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-2:0] file_addr,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] rd_data,
  input logic [2:0]    ext_sel,
  input logic          ext_we,
  input logic [DW-1:0] ptr_q
);
  localparam int OW = DW - 1;

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ext_sel)); // R5
  AST_STAT_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (file_addr == OW'(3)) |-> (ext_sel == 3'b010)); // R5
  AST_EXT_WE_SEL: assert property (@(posedge clk) disable iff (!rst_n) ext_we |-> (ext_sel != 3'b000)); // R8
  AST_NULL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (file_addr == OW'(0) && ptr_q[OW-1:0] == OW'(0)) |-> (rd_data == '0 && ext_sel == 3'b000)); // R4
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> $stable(ptr_q)); // R6
  AST_PTR_DIRECT_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && file_addr == OW'(4)) |=> (ptr_q == $past(wr_data))); // R2
  AST_PTR_SELF_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && file_addr == OW'(0) && ptr_q[OW-1:0] == OW'(4)) |=> (ptr_q == $past(wr_data))); // R7
  AST_RAM_NOSEL: assert property (@(posedge clk) disable iff (!rst_n)
    (file_addr > OW'(10)) |-> (ext_sel == 3'b000 && !ext_we)); // R8
endmodule

bind bank_addr_unit bank_addr_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .file_addr(file_addr), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .ext_sel(ext_sel),
  .ext_we(ext_we), .ptr_q(ptr_q)
);

// File: tb/test_bank_addr_unit.sv
module test_bank_addr_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic       clk = 0, rst_n = 0;
  logic [6:0] file_addr = '0;
  logic       bank_sel = 0, wr_en = 0;
  logic [7:0] wr_data = '0, ext_rd_data = '0;
  logic [7:0] rd_data;
  logic [2:0] ext_sel;
  logic       ext_we;

  int checks = 0, errors = 0;
  logic [7:0] m_mem [256];
  bit         m_val [256];
  logic [7:0] m_ptr;

  bank_addr_unit i_bank_addr_unit (
    .clk(clk), .rst_n(rst_n), .file_addr(file_addr), .bank_sel(bank_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .ext_sel(ext_sel),
    .ext_we(ext_we), .ext_rd_data(ext_rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] eff_of(logic [6:0] fa, logic b);
    return (fa == 7'd0) ? m_ptr : {b, fa};
  endfunction

  function automatic logic [2:0] sel_of(logic [7:0] ea);
    case (ea[6:0])
      7'h02: return 3'b001;
      7'h03: return 3'b010;
      7'h0A: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(logic [6:0] fa, logic b, logic we, logic [7:0] wd);
    logic [7:0] ea, exr;
    logic [2:0] es;
    string tag;
    exr = 8'($urandom);
    file_addr = fa; bank_sel = b; wr_en = we; wr_data = wd; ext_rd_data = exr;
    #1;
    ea = eff_of(fa, b);
    es = sel_of(ea);
    tag = (fa == 7'd0) ? "R3" : "R1";
    check("R5 ext_sel", {5'd0, ext_sel}, {5'd0, es});
    check("R5 ext_we", {7'd0, ext_we}, {7'd0, we && (es != 0)});
    if (ea[6:0] == 7'd0)      check("R4 null read", rd_data, 8'h00);
    else if (ea[6:0] == 7'd4) check("R2 pointer read", rd_data, m_ptr);
    else if (es != 0)         check("R5 ext read", rd_data, exr);
    else if (m_val[ea])       check(tag, rd_data, m_mem[ea]);
    @(posedge clk);
    if (we) begin
      if (ea[6:0] == 7'd4) m_ptr = wd;
      else if (ea[6:0] != 7'd0 && es == 0) begin m_mem[ea] = wd; m_val[ea] = 1; end
    end
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    m_ptr = 8'h00;
    for (int i = 0; i < 256; i++) m_val[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // reset state: pointer 0, so offset 0 is null
    file_addr = 7'h04; bank_sel = 1; #1;
    check("R2 reset pointer", rd_data, 8'h00);
    file_addr = 7'h00; #1;
    check("R4 null after reset", rd_data, 8'h00);
    @(negedge clk);

    // R1 banks are distinct
    access(7'h20, 0, 1, 8'hAA);
    access(7'h20, 1, 1, 8'h55);
    access(7'h20, 0, 0, 8'h00);
    access(7'h20, 1, 0, 8'h00);
    // R2 pointer mirrored: write via bank 1, read via bank 0
    access(7'h04, 1, 1, 8'hA0);
    access(7'h04, 0, 0, 8'h00);
    // R3 indirect write lands on 0xA0 = bank1 offset 0x20
    access(7'h00, 0, 1, 8'h3C);
    access(7'h20, 1, 0, 8'h00);
    // R6 write enable low changes nothing
    access(7'h20, 1, 0, 8'hFF);
    access(7'h20, 1, 0, 8'h00);
    // R4 pointer at 0x80: write discarded, read zero
    access(7'h04, 0, 1, 8'h80);
    access(7'h00, 1, 1, 8'h77);
    access(7'h00, 0, 0, 8'h00);
    // R7 pointer at 0x84: indirect write reloads pointer
    access(7'h04, 0, 1, 8'h84);
    access(7'h00, 0, 1, 8'h33);
    access(7'h04, 1, 0, 8'h00);
    // R5 R8 external selects in both banks
    access(7'h03, 1, 1, 8'h11);
    access(7'h0A, 0, 0, 8'h00);
    access(7'h02, 1, 1, 8'h22);
    access(7'h40, 1, 1, 8'h22);

    // R3 full indirect sweep
    for (int i = 0; i < 256; i++) begin
      access(7'h04, 8'(i) >> 7, 1, 8'(i));
      access(7'h00, 0, 1, 8'(i) ^ 8'h5A);
      access(7'h04, 0, 1, 8'(i));
      access(7'h00, 1, 0, 8'h00);
    end

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic [6:0] fa;
      fa = ($urandom_range(0, 3) == 0) ? 7'($urandom_range(0, 11)) : 7'($urandom);
      access(fa, 1'($urandom), ($urandom_range(0, 2) == 0), 8'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule